// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block is the tag side of a coherent cache controller. For every way of every set it keeps a line address, an access-permission state and a lock owner. A controller issues one operation at a time on the request port with a line-aligned address. Each operation either asks a question or changes state, and one cycle later the block answers with a hit flag, a way number, a grant flag, an error flag and, for the victim operation, the address of the line to evict. Supported operations are: permission-checked access, availability probe, allocate, deallocate, victim probe, lock set, lock clear, lock test, recency touch, and permission write. Recency is kept per set by age counters. Data storage, the coherence protocol and statistics are outside the block.

The control path is a two-state machine. ST_IDLE raises `req_ready`. The transition ACCEPT (req_valid with req_ready) latches the request and moves to ST_EXEC. In ST_EXEC the addressed set is read, every array update commits, and the response registers load. The transition RESPOND then returns to ST_IDLE and pulses `resp_valid` for one cycle. The set index is `NUM_SETS` = `CAPACITY / WAYS / LINE_BYTES` sets wide in log2 terms and is taken from the address starting at bit `IDX_LO`.

Top module: `tag_directory`

## Requirements
- R1: After reset every way is empty, `resp_valid` is 0 and `req_ready` is 1. The ages of way w start at w, so the first victim is the highest way.
- R2: A request accepted at clock edge k gives `resp_valid` high for exactly the one cycle after edge k+1. `req_ready` is low between those edges.
- R3: The set is `req_addr[IDX_LO +: log2(NUM_SETS)]`. Addresses in different sets never compete for ways.
- R4: `resp_hit` is 1 when an occupied way holds exactly `req_addr` and its permission is not NotPresent. `resp_way` then names that way. Permission codes are NotPresent=0, Invalid=1, ReadOnly=2, ReadWrite=3, Busy=4.
- R5: Op access (code 0) grants for every request type on a ReadWrite hit. On a ReadOnly hit it grants only for load (type 0) and instruction fetch (type 1); store is type 2 and atomic is type 3. It refuses all other cases.
- R6: Op availability probe (code 1) grants when some way of the set holds the address, is empty, or is NotPresent.
- R7: Op allocate (code 2) writes the lowest-numbered empty or NotPresent way. It sets the permission to Invalid, clears the lock owner, and returns that way with grant 1.
- R8: Allocating an address that already hits, or allocating into a set with no free way, returns error 1 and grant 0 and changes nothing.
- R9: A hit on op access (0) or op touch (8) makes that way the youngest (age 0) and ages every way that was younger by one. Allocate changes recency only when `req_touch` is 1.
- R10: Op victim (code 4) on a set with no free way returns the oldest way and its stored address with grant 1. On a set with a free way it returns error 1.
- R11: Op deallocate (code 3) empties the hitting way with grant 1. On a miss it returns error 1.
- R12: Op lock set (5) records `req_ctx` as owner and op lock clear (6) removes the owner. Op lock test (7) grants only when the stored owner equals `req_ctx`. All three return error 1 when the line does not hit.
- R13: Op permission write (code 9) stores `req_perm` into the way holding the address, whatever that way's current permission. With no such way it returns error 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Line-aligned address |
| req_type | input | 2 | Access type for op access |
| req_ctx | input | CTX_W | Context for lock operations |
| req_perm | input | 3 | Permission for op permission write |
| req_touch | input | 1 | Allocate also updates recency |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Permission-aware tag match before the update |
| resp_way | output | log2(WAYS) | Matched, allocated or victim way |
| resp_grant | output | 1 | Operation-specific success or grant |
| resp_error | output | 1 | Illegal operation; state unchanged |
| resp_victim | output | ADDR_W | Victim line address (op victim only) |

## Verification
The assertions assume the controller never holds the same address in two present ways. Allocate refuses duplicates, so this holds as long as every present line enters through allocate. The bench creates lines only that way. The assertions also assume `req_op` stays within the defined codes when a grant is checked. The stimulus follows the valid/ready handshake, keeps one request in flight, and uses only line-aligned addresses with the offset bits clear. It checks recency through the victim probe, checks locks through lock test, and checks error cases by probing the set again afterwards.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
    typedef enum logic [3:0] {
        OP_ACCESS   = 4'd0,
        OP_AVAIL    = 4'd1,
        OP_ALLOC    = 4'd2,
        OP_DEALLOC  = 4'd3,
        OP_VICTIM   = 4'd4,
        OP_LOCK_SET = 4'd5,
        OP_LOCK_CLR = 4'd6,
        OP_LOCK_TST = 4'd7,
        OP_TOUCH    = 4'd8,
        OP_SET_PERM = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        PERM_NOT_PRESENT = 3'd0,
        PERM_INVALID     = 3'd1,
        PERM_READ_ONLY   = 3'd2,
        PERM_READ_WRITE  = 3'd3,
        PERM_BUSY        = 3'd4
    } perm_e;

    typedef enum logic [1:0] {
        RQ_LOAD   = 2'd0,
        RQ_IFETCH = 2'd1,
        RQ_STORE  = 2'd2,
        RQ_ATOMIC = 2'd3
    } rtype_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } state_e;
endpackage

// File: rtl/tagdir_first_one.sv
module tagdir_first_one #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/tagdir_way_match.sv
module tagdir_way_match #(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 16,
    parameter int WB     = 2
) (
    input  logic [WAYS-1:0]             occ,
    input  logic [WAYS-1:0][ADDR_W-1:0] lines,
    input  logic [WAYS-1:0][2:0]        perms,
    input  logic [ADDR_W-1:0]           key,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit,
    output logic [WB-1:0]               hit_way,
    output logic                        raw_hit,
    output logic [WB-1:0]               raw_way,
    output logic                        any_free,
    output logic [WB-1:0]               free_way,
    output logic                        has_key
);
    import tagdir_pkg::*;

    logic [WAYS-1:0] raw_vec;
    logic [WAYS-1:0] free_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign raw_vec[w]  = occ[w] && (lines[w] == key);
        assign hit_vec[w]  = raw_vec[w] && (perms[w] != PERM_NOT_PRESENT);
        assign free_vec[w] = !occ[w] || (perms[w] == PERM_NOT_PRESENT);
    end

    assign has_key = |raw_vec;

    tagdir_first_one #(.N(WAYS), .W(WB)) i_hit_enc (
        .vec(hit_vec), .found(hit), .idx(hit_way)
    );
    tagdir_first_one #(.N(WAYS), .W(WB)) i_raw_enc (
        .vec(raw_vec), .found(raw_hit), .idx(raw_way)
    );
    tagdir_first_one #(.N(WAYS), .W(WB)) i_free_enc (
        .vec(free_vec), .found(any_free), .idx(free_way)
    );
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    parameter int SB   = 2,
    parameter int WB   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [SB-1:0] touch_set,
    input  logic [WB-1:0] touch_way,
    input  logic [SB-1:0] rd_set,
    output logic [WB-1:0] victim_way
);
    logic [WB-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WB'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WB'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (age_q[rd_set][w] > age_q[rd_set][victim_way]) victim_way = WB'(w);
        end
    end

    // R10: ages stay a permutation, so the chosen victim carries the top age
    p_victim_oldest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        age_q[rd_set][victim_way] == WB'(WAYS - 1));
endmodule

// File: rtl/tag_directory.sv
module tag_directory #(
    parameter int ADDR_W     = 16,
    parameter int CAPACITY   = 1024,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 64,
    parameter int IDX_LO     = 6,
    parameter int CTX_W      = 4,
    localparam int NUM_SETS  = CAPACITY / WAYS / LINE_BYTES,
    localparam int SET_BITS  = $clog2(NUM_SETS),
    localparam int WAY_BITS  = $clog2(WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [3:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_type,
    input  logic [CTX_W-1:0]    req_ctx,
    input  logic [2:0]          req_perm,
    input  logic                req_touch,
    output logic                resp_valid,
    output logic                resp_hit,
    output logic [WAY_BITS-1:0] resp_way,
    output logic                resp_grant,
    output logic                resp_error,
    output logic [ADDR_W-1:0]   resp_victim
);
    import tagdir_pkg::*;

    if (NUM_SETS < 2) begin : g_bad_geometry
        $error("tag_directory needs at least two sets");
    end

    // request latch and state
    state_e              state_q;
    op_e                 op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [1:0]          type_q;
    logic [CTX_W-1:0]    ctx_q;
    logic [2:0]          nperm_q;
    logic                touch_q;

    // directory arrays
    logic                occ_q   [NUM_SETS][WAYS];
    logic [ADDR_W-1:0]   line_q  [NUM_SETS][WAYS];
    logic [2:0]          perm_q  [NUM_SETS][WAYS];
    logic                held_q  [NUM_SETS][WAYS];
    logic [CTX_W-1:0]    owner_q [NUM_SETS][WAYS];

    logic [SET_BITS-1:0] set_idx;
    assign set_idx = addr_q[IDX_LO +: SET_BITS];

    // selected set, flattened for the matcher
    logic [WAYS-1:0]             row_occ;
    logic [WAYS-1:0][ADDR_W-1:0] row_line;
    logic [WAYS-1:0][2:0]        row_perm;
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_occ[w]  = occ_q[set_idx][w];
            row_line[w] = line_q[set_idx][w];
            row_perm[w] = perm_q[set_idx][w];
        end
    end

    logic [WAYS-1:0]     hit_vec;
    logic                hit, raw_hit, any_free, has_key;
    logic [WAY_BITS-1:0] hit_way, raw_way, free_way, victim_way;

    tagdir_way_match #(.WAYS(WAYS), .ADDR_W(ADDR_W), .WB(WAY_BITS)) i_match (
        .occ(row_occ), .lines(row_line), .perms(row_perm), .key(addr_q),
        .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way),
        .raw_hit(raw_hit), .raw_way(raw_way),
        .any_free(any_free), .free_way(free_way), .has_key(has_key)
    );

    // execute-stage decisions
    logic                do_touch, wr_alloc, wr_free, wr_lock, lock_val, wr_perm;
    logic [WAY_BITS-1:0] tgt_way;
    logic                x_grant, x_error;
    logic [WAY_BITS-1:0] x_way;
    logic [ADDR_W-1:0]   x_victim;

    tagdir_lru #(.SETS(NUM_SETS), .WAYS(WAYS), .SB(SET_BITS), .WB(WAY_BITS)) i_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(do_touch && (state_q == ST_EXEC)),
        .touch_set(set_idx), .touch_way(tgt_way),
        .rd_set(set_idx), .victim_way(victim_way)
    );

    always_comb begin
        do_touch = 1'b0;
        wr_alloc = 1'b0;
        wr_free  = 1'b0;
        wr_lock  = 1'b0;
        lock_val = 1'b0;
        wr_perm  = 1'b0;
        tgt_way  = hit_way;
        x_grant  = 1'b0;
        x_error  = 1'b0;
        x_way    = hit_way;
        x_victim = '0;
        unique case (op_q)
            OP_ACCESS: begin
                do_touch = hit;
                if (hit) begin
                    if (row_perm[hit_way] == PERM_READ_WRITE) begin
                        x_grant = 1'b1;
                    end else if (row_perm[hit_way] == PERM_READ_ONLY) begin
                        x_grant = (type_q == RQ_LOAD) || (type_q == RQ_IFETCH);
                    end
                end
            end
            OP_AVAIL: x_grant = has_key || any_free;
            OP_ALLOC: begin
                if (hit || !any_free) begin
                    x_error = 1'b1;
                end else begin
                    wr_alloc = 1'b1;
                    x_grant  = 1'b1;
                    tgt_way  = free_way;
                    x_way    = free_way;
                    do_touch = touch_q;
                end
            end
            OP_DEALLOC: begin
                wr_free = hit;
                x_grant = hit;
                x_error = !hit;
            end
            OP_VICTIM: begin
                x_way = victim_way;
                if (any_free) begin
                    x_error = 1'b1;
                end else begin
                    x_grant  = 1'b1;
                    x_victim = row_line[victim_way];
                end
            end
            OP_LOCK_SET, OP_LOCK_CLR: begin
                wr_lock  = hit;
                lock_val = (op_q == OP_LOCK_SET);
                x_grant  = hit;
                x_error  = !hit;
            end
            OP_LOCK_TST: begin
                x_error = !hit;
                x_grant = hit && held_q[set_idx][hit_way] &&
                          (owner_q[set_idx][hit_way] == ctx_q);
            end
            OP_TOUCH: begin
                do_touch = hit;
                x_grant  = hit;
            end
            OP_SET_PERM: begin
                tgt_way = raw_way;
                x_way   = raw_way;
                wr_perm = raw_hit;
                x_grant = raw_hit;
                x_error = !raw_hit;
            end
            default: x_error = 1'b1;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_ACCESS;
            addr_q  <= '0;
            type_q  <= '0;
            ctx_q   <= '0;
            nperm_q <= '0;
            touch_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    state_q <= ST_EXEC;
                    op_q    <= op_e'(req_op);
                    addr_q  <= req_addr;
                    type_q  <= req_type;
                    ctx_q   <= req_ctx;
                    nperm_q <= req_perm;
                    touch_q <= req_touch;
                end
                ST_EXEC: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // array commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    occ_q[s][w]   <= 1'b0;
                    line_q[s][w]  <= '0;
                    perm_q[s][w]  <= PERM_NOT_PRESENT;
                    held_q[s][w]  <= 1'b0;
                    owner_q[s][w] <= '0;
                end
            end
        end else if (state_q == ST_EXEC) begin
            if (wr_alloc) begin
                occ_q[set_idx][tgt_way]   <= 1'b1;
                line_q[set_idx][tgt_way]  <= addr_q;
                perm_q[set_idx][tgt_way]  <= PERM_INVALID;
                held_q[set_idx][tgt_way]  <= 1'b0;
                owner_q[set_idx][tgt_way] <= '0;
            end
            if (wr_free) begin
                occ_q[set_idx][tgt_way]  <= 1'b0;
                perm_q[set_idx][tgt_way] <= PERM_NOT_PRESENT;
                held_q[set_idx][tgt_way] <= 1'b0;
            end
            if (wr_lock) begin
                held_q[set_idx][tgt_way]  <= lock_val;
                owner_q[set_idx][tgt_way] <= lock_val ? ctx_q : '0;
            end
            if (wr_perm) begin
                perm_q[set_idx][tgt_way] <= nperm_q;
            end
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_way    <= '0;
            resp_grant  <= 1'b0;
            resp_error  <= 1'b0;
            resp_victim <= '0;
        end else begin
            resp_valid <= (state_q == ST_EXEC);
            if (state_q == ST_EXEC) begin
                resp_hit    <= hit;
                resp_way    <= x_way;
                resp_grant  <= x_grant;
                resp_error  <= x_error;
                resp_victim <= x_victim;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);

    // R2: accepted request answers after exactly two edges, as a one-cycle pulse
    p_accept_to_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 resp_valid);
    p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R4/R8: allocate refuses duplicates, so at most one present way matches
    p_unique_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R5: an access grant is only possible on a hit
    p_grant_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && op_q == OP_ACCESS && resp_grant) |-> resp_hit);
    // R8: a refused operation never also reports success
    p_error_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_grant && resp_error));
endmodule

// File: tb/test_tag_directory.sv
module test_tag_directory;
    localparam int ADDR_W = 16;
    localparam int CTX_W  = 4;
    localparam int WB     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [3:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_type = '0;
    logic [CTX_W-1:0]  req_ctx = '0;
    logic [2:0]        req_perm = '0;
    logic              req_touch = 1'b0;
    logic              resp_valid, resp_hit, resp_grant, resp_error;
    logic [WB-1:0]     resp_way;
    logic [ADDR_W-1:0] resp_victim;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tag_directory i_tag_directory (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_type(req_type),
        .req_ctx(req_ctx), .req_perm(req_perm), .req_touch(req_touch),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
        .resp_grant(resp_grant), .resp_error(resp_error), .resp_victim(resp_victim)
    );

    localparam logic [3:0] ACC = 0, AVL = 1, ALC = 2, DEA = 3, VIC = 4,
                           LKS = 5, LKC = 6, LKT = 7, TCH = 8, SPM = 9;

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
        return ADDR_W'((tag << 8) | (set << 6));
    endfunction

    task automatic chk(input string req, input logic ok, input string act, input string exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    // one request through the handshake; response sampled at the negedge after resp rises
    task automatic issue(input logic [3:0] op, input logic [ADDR_W-1:0] a,
                         input logic [1:0] t, input int ctx, input logic [2:0] p, input logic tc);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_type = t;
        req_ctx = CTX_W'(ctx); req_perm = p; req_touch = tc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_resp(input string req, input logic h, input int w, input logic g,
                               input logic e, input bit cv, input logic [ADDR_W-1:0] v);
        logic ok;
        ok = resp_valid && resp_hit == h && resp_grant == g && resp_error == e &&
             (w < 0 || resp_way == WB'(w)) && (!cv || resp_victim == v);
        chk(req, ok,
            $sformatf("v%0d h%0d w%0d g%0d e%0d vic%h", resp_valid, resp_hit, resp_way,
                      resp_grant, resp_error, resp_victim),
            $sformatf("v1 h%0d w%0d g%0d e%0d vic%h", h, w, g, e, v));
    endtask

    task automatic t_reset;
        chk("R1 reset resp_valid", resp_valid == 1'b0, $sformatf("%0d", resp_valid), "0");
        chk("R1 reset req_ready", req_ready == 1'b1, $sformatf("%0d", req_ready), "1");
        issue(AVL, mk(1, 0), 0, 0, 0, 0);
        expect_resp("R1 R6 empty set available", 0, -1, 1, 0, 0, '0);
        issue(VIC, mk(1, 0), 0, 0, 0, 0);
        expect_resp("R1 R10 victim on empty set", 0, -1, 0, 1, 0, '0);
    endtask

    task automatic t_handshake;
        @(negedge clk);
        req_valid = 1'b1; req_op = AVL; req_addr = mk(2, 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ready low while executing", req_ready == 1'b0, $sformatf("%0d", req_ready), "0");
        chk("R2 no response yet", resp_valid == 1'b0, $sformatf("%0d", resp_valid), "0");
        @(posedge clk);
        @(negedge clk);
        chk("R2 response strobe", resp_valid == 1'b1, $sformatf("%0d", resp_valid), "1");
        @(posedge clk);
        @(negedge clk);
        chk("R2 strobe lasts one cycle", resp_valid == 1'b0, $sformatf("%0d", resp_valid), "0");
    endtask

    task automatic t_fill_lru;
        for (int k = 0; k < 4; k++) begin
            issue(ALC, mk(16 + k, 1), 0, 0, 0, 1);
            expect_resp("R7 allocate lowest way", 0, k, 1, 0, 0, '0);
        end
        // ages [3,2,1,0] -> way0 oldest
        issue(VIC, mk(99, 1), 0, 0, 0, 0);
        expect_resp("R10 victim after fill", 0, 0, 1, 0, 1, mk(16, 1));
        issue(ACC, mk(16, 1), 0, 0, 0, 0);
        expect_resp("R5 R4 invalid line hits but refuses", 1, 0, 0, 0, 0, '0);
        issue(VIC, mk(99, 1), 0, 0, 0, 0);
        expect_resp("R9 access refreshes recency", 0, 1, 1, 0, 1, mk(17, 1));
        issue(TCH, mk(18, 1), 0, 0, 0, 0);
        expect_resp("R9 touch hit", 1, 2, 1, 0, 0, '0);
        issue(VIC, mk(99, 1), 0, 0, 0, 0);
        expect_resp("R9 touch keeps way1 oldest", 0, 1, 1, 0, 1, mk(17, 1));
    endtask

    task automatic t_full_set;
        issue(AVL, mk(16, 1), 0, 0, 0, 0);
        expect_resp("R6 full set holding address", 1, 0, 1, 0, 0, '0);
        issue(AVL, mk(22, 1), 0, 0, 0, 0);
        expect_resp("R6 full set new address", 0, -1, 0, 0, 0, '0);
        issue(ALC, mk(22, 1), 0, 0, 0, 1);
        expect_resp("R8 allocate into full set", 0, -1, 0, 1, 0, '0);
        issue(ACC, mk(22, 1), 0, 0, 0, 0);
        expect_resp("R8 refused address absent", 0, -1, 0, 0, 0, '0);
        issue(ALC, mk(16, 1), 0, 0, 0, 1);
        expect_resp("R8 duplicate allocate", 1, 0, 0, 1, 0, '0);
        issue(VIC, mk(99, 1), 0, 0, 0, 0);
        expect_resp("R8 recency untouched by errors", 0, 1, 1, 0, 1, mk(17, 1));
        issue(ACC, mk(16, 0), 0, 0, 0, 0);
        expect_resp("R3 same tag other set misses", 0, -1, 0, 0, 0, '0);
    endtask

    task automatic t_dealloc;
        issue(DEA, mk(17, 1), 0, 0, 0, 0);
        expect_resp("R11 deallocate hit", 1, 1, 1, 0, 0, '0);
        issue(ACC, mk(17, 1), 0, 0, 0, 0);
        expect_resp("R11 line gone", 0, -1, 0, 0, 0, '0);
        issue(VIC, mk(99, 1), 0, 0, 0, 0);
        expect_resp("R10 victim with free way", 0, -1, 0, 1, 0, '0);
        issue(ALC, mk(21, 1), 0, 0, 0, 0);
        expect_resp("R7 allocate into freed way", 0, 1, 1, 0, 0, '0);
        issue(VIC, mk(99, 1), 0, 0, 0, 0);
        expect_resp("R9 untouched allocate stays oldest", 0, 1, 1, 0, 1, mk(21, 1));
        issue(DEA, mk(23, 1), 0, 0, 0, 0);
        expect_resp("R11 deallocate miss", 0, -1, 0, 1, 0, '0);
    endtask

    task automatic t_grant;
        issue(ALC, mk(32, 2), 0, 0, 0, 1);
        expect_resp("R7 allocate set2", 0, 0, 1, 0, 0, '0);
        issue(SPM, mk(32, 2), 0, 0, 2, 0);
        expect_resp("R13 write read-only", 1, 0, 1, 0, 0, '0);
        issue(ACC, mk(32, 2), 0, 0, 0, 0);
        expect_resp("R5 read-only load", 1, 0, 1, 0, 0, '0);
        issue(ACC, mk(32, 2), 1, 0, 0, 0);
        expect_resp("R5 read-only ifetch", 1, 0, 1, 0, 0, '0);
        issue(ACC, mk(32, 2), 2, 0, 0, 0);
        expect_resp("R5 read-only store refused", 1, 0, 0, 0, 0, '0);
        issue(SPM, mk(32, 2), 0, 0, 3, 0);
        expect_resp("R13 write read-write", 1, 0, 1, 0, 0, '0);
        issue(ACC, mk(32, 2), 2, 0, 0, 0);
        expect_resp("R5 read-write store", 1, 0, 1, 0, 0, '0);
        issue(ACC, mk(32, 2), 3, 0, 0, 0);
        expect_resp("R5 read-write atomic", 1, 0, 1, 0, 0, '0);
        issue(SPM, mk(32, 2), 0, 0, 4, 0);
        expect_resp("R13 write busy", 1, 0, 1, 0, 0, '0);
        issue(ACC, mk(32, 2), 0, 0, 0, 0);
        expect_resp("R5 busy refused", 1, 0, 0, 0, 0, '0);
        issue(SPM, mk(32, 2), 0, 0, 0, 0);
        expect_resp("R13 write not-present", 1, 0, 1, 0, 0, '0);
        issue(ACC, mk(32, 2), 0, 0, 0, 0);
        expect_resp("R4 not-present misses", 0, -1, 0, 0, 0, '0);
        issue(ALC, mk(33, 2), 0, 0, 0, 1);
        expect_resp("R7 reuse not-present way", 0, 0, 1, 0, 0, '0);
        issue(ACC, mk(33, 2), 0, 0, 0, 0);
        expect_resp("R4 new line hits", 1, 0, 0, 0, 0, '0);
        issue(SPM, mk(34, 2), 0, 0, 3, 0);
        expect_resp("R13 write absent", 0, -1, 0, 1, 0, '0);
    endtask

    task automatic t_lock;
        issue(ALC, mk(48, 3), 0, 0, 0, 1);
        expect_resp("R7 allocate set3", 0, 0, 1, 0, 0, '0);
        issue(LKT, mk(48, 3), 0, 5, 0, 0);
        expect_resp("R12 fresh line unlocked", 1, 0, 0, 0, 0, '0);
        issue(LKS, mk(48, 3), 0, 5, 0, 0);
        expect_resp("R12 lock set", 1, 0, 1, 0, 0, '0);
        issue(LKT, mk(48, 3), 0, 5, 0, 0);
        expect_resp("R12 owner matches", 1, 0, 1, 0, 0, '0);
        issue(LKT, mk(48, 3), 0, 6, 0, 0);
        expect_resp("R12 other context", 1, 0, 0, 0, 0, '0);
        issue(LKC, mk(48, 3), 0, 0, 0, 0);
        expect_resp("R12 lock clear", 1, 0, 1, 0, 0, '0);
        issue(LKT, mk(48, 3), 0, 5, 0, 0);
        expect_resp("R12 cleared owner", 1, 0, 0, 0, 0, '0);
        issue(LKS, mk(48, 3), 0, 7, 0, 0);
        issue(DEA, mk(48, 3), 0, 0, 0, 0);
        issue(ALC, mk(48, 3), 0, 0, 0, 1);
        expect_resp("R7 reallocate", 0, 0, 1, 0, 0, '0);
        issue(LKT, mk(48, 3), 0, 7, 0, 0);
        expect_resp("R7 allocate clears owner", 1, 0, 0, 0, 0, '0);
        issue(LKS, mk(49, 3), 0, 2, 0, 0);
        expect_resp("R12 lock set absent", 0, -1, 0, 1, 0, '0);
        issue(LKT, mk(49, 3), 0, 2, 0, 0);
        expect_resp("R12 lock test absent", 0, -1, 0, 1, 0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_fill_lru();
        t_full_set();
        t_dealloc();
        t_grant();
        t_lock();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule